// File: doc/BRIEF.md
# Zero-Pair Triggered Window Checker

This block watches a serial bit stream `x`, one bit per clock, and raises `z` when a short window of interest contains a 1. The window opens only after the stream has delivered two 0 bits in a row. The three bits that follow that pair form the window. If any of them is 1, `z` goes high in the same cycle as the third window bit. Because `z` is a Mealy output, it responds combinationally to the live input during that last slot.

Once a window has been judged, the block always goes back to hunting for a fresh pair of 0s, whether or not it reported a hit. Zeros that fall inside a window never count toward the next trigger, so matches do not overlap. A synchronous, active-high reset returns the block to the hunting state with no zeros counted.

The position inside the window can be held as a binary counter or as a one-hot shift register. A parameter selects the encoding, and the behaviour at the ports is the same for both.

Top module: `zero_pair_window`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to hunting with no zeros counted. After that edge, `z` is 0, and any partial trigger or open window from before the reset has no effect on later outputs.
- R2: When two consecutive 0 bits arrive while the block is hunting, a window opens on the very next bit.
- R3: While hunting, a 1 bit discards a single pending 0. A pattern such as 0,1,0 therefore never opens a window.
- R4: A window spans exactly three bits. A 1 that arrives after the third window bit does not affect the verdict, and `z` is never 1 outside the third window slot.
- R5: In the third window slot, `z` equals 1 exactly when at least one of the three window bits is 1. Otherwise `z` is 0.
- R6: After the third window slot, the block hunts again with no zeros counted. Zeros inside the window do not count toward the next trigger.
- R7: In the third window slot, `z` follows the current `x` combinationally. When the first two window bits are 0, `x`=0 gives `z`=0 and `x`=1 gives `z`=1 within the same cycle.
- R8: From reset, the stream 0100010010010010000000011 (first bit leftmost) gives the output stream 0000001000000100000000001.
- R9: Setting `POS_ONEHOT` to 1 (one-hot window position) or to 0 (binary counter) gives identical `z` for every input stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| x | input | 1 | Serial input bit, sampled each clock |
| z | output | 1 | Mealy verdict, high during the third window slot if the window held a 1 |

## Verification
The bench builds two copies of the block side by side: one with the default binary window position (`POS_ONEHOT`=0) and one with the one-hot variant (`POS_ONEHOT`=1). Both copies see every stimulus.

The main stimulus is a sweep of all 1024 ten-bit streams, each started from reset. Ten bits are enough to reach back-to-back windows, a window cut off at the end of the stream, and every placement of 1s inside and around a window. This sweep also shows that the two encodings agree everywhere.

Directed streams cover the following cases:
- the worked example stream;
- a broken trigger;
- a 1 just past the window;
- zeros inside a window that must not count as a trigger;
- a reset in the middle of a window;
- a change of `x` within one cycle during the third slot.

// File: rtl/zpw_pkg.sv
package zpw_pkg;

  localparam int PAIR_LEN = 2;
  localparam int WIN_LEN  = 3;

  typedef enum logic [0:0] {
    HUNT_NONE = 1'b0,
    HUNT_ONE  = 1'b1
  } hunt_t;

  // next hunting state for one input bit while no window is open
  function automatic hunt_t hunt_next(input hunt_t cur, input logic bit_in);
    if (bit_in)            return HUNT_NONE;
    else if (cur == HUNT_ONE) return HUNT_NONE;
    else                   return HUNT_ONE;
  endfunction

  // trigger condition: pending zero followed by another zero
  function automatic logic pair_complete(input hunt_t cur, input logic bit_in);
    return (cur == HUNT_ONE) && !bit_in;
  endfunction

  // verdict for the final slot: any 1 seen earlier or the live bit
  function automatic logic window_verdict(input logic seen, input logic bit_in);
    return seen | bit_in;
  endfunction

endpackage

// File: rtl/zpw_hunt.sv
module zpw_hunt
  import zpw_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  x,
  input  logic  busy,
  output logic  fire,
  output hunt_t hunt_state
);

  hunt_t state_q;

  always_ff @(posedge clk) begin
    if (rst || busy) state_q <= HUNT_NONE;
    else             state_q <= hunt_next(state_q, x);
  end

  assign fire       = !busy && pair_complete(state_q, x);
  assign hunt_state = state_q;

  // R3
  one_clears_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && x) |=> (hunt_state == HUNT_NONE));

  // R6
  window_holds_idle_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (hunt_state == HUNT_NONE));

  // R2
  fire_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> ($past(!x) && !x));

endmodule

// File: rtl/zpw_window.sv
module zpw_window
  import zpw_pkg::*;
#(
  parameter bit POS_ONEHOT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic x,
  input  logic start,
  output logic busy,
  output logic last_slot,
  output logic seen,
  output logic verdict
);

  localparam int CW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [CW-1:0] LAST_POS = CW'(WIN_LEN - 1);

  logic seen_q;

  generate
    if (POS_ONEHOT) begin : g_onehot
      logic [WIN_LEN-1:0] slot_q;
      always_ff @(posedge clk) begin
        if (rst)        slot_q <= '0;
        else if (start) slot_q <= WIN_LEN'(1);
        else            slot_q <= slot_q << 1;
      end
      assign busy      = |slot_q;
      assign last_slot = slot_q[WIN_LEN-1];

      // R9
      slot_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_q));
    end else begin : g_binary
      logic          act_q;
      logic [CW-1:0] pos_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          act_q <= 1'b0;
          pos_q <= '0;
        end else if (start) begin
          act_q <= 1'b1;
          pos_q <= '0;
        end else if (act_q) begin
          if (pos_q == LAST_POS) begin
            act_q <= 1'b0;
            pos_q <= '0;
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
      end
      assign busy      = act_q;
      assign last_slot = act_q && (pos_q == LAST_POS);

      // R9
      pos_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        act_q |-> (pos_q <= LAST_POS));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || start) seen_q <= 1'b0;
    else if (busy)    seen_q <= seen_q | x;
  end

  assign seen    = seen_q;
  assign verdict = last_slot && window_verdict(seen_q, x);

  // R2
  start_opens_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && !last_slot && !seen));

  // R4
  last_closes_chk: assert property (@(posedge clk) disable iff (rst)
    last_slot |=> !busy);

  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

endmodule

// File: rtl/zero_pair_window.sv
module zero_pair_window
  import zpw_pkg::*;
#(
  parameter bit POS_ONEHOT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic x,
  output logic z
);

  logic  fire;
  logic  busy;
  logic  last_slot;
  logic  seen;
  logic  verdict;
  hunt_t hunt_state;

  zpw_hunt u_hunt (
    .clk        (clk),
    .rst        (rst),
    .x          (x),
    .busy       (busy),
    .fire       (fire),
    .hunt_state (hunt_state)
  );

  zpw_window #(.POS_ONEHOT(POS_ONEHOT)) u_window (
    .clk       (clk),
    .rst       (rst),
    .x         (x),
    .start     (fire),
    .busy      (busy),
    .last_slot (last_slot),
    .seen      (seen),
    .verdict   (verdict)
  );

  assign z = verdict;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!z && hunt_state == HUNT_NONE));

  // R4
  z_only_last_chk: assert property (@(posedge clk) disable iff (rst)
    z |-> last_slot);

  // R7
  live_one_hits_chk: assert property (@(posedge clk) disable iff (rst)
    (last_slot && x) |-> z);

  // R5
  empty_window_chk: assert property (@(posedge clk) disable iff (rst)
    (last_slot && !seen && !x) |-> !z);

  // R2
  fire_then_window_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> busy);

endmodule

// File: tb/zero_pair_window_test.sv
`timescale 1ns/1ps
module zero_pair_window_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x   = 1'b0;
  logic z_bin, z_oh;
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  always #10 clk = ~clk;

  zero_pair_window #(.POS_ONEHOT(1'b0)) uut    (.clk(clk), .rst(rst), .x(x), .z(z_bin));
  zero_pair_window #(.POS_ONEHOT(1'b1)) uut_oh (.clk(clk), .rst(rst), .x(x), .z(z_oh));

  task automatic check(input logic act, input logic exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: z=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_both(input logic exp, input string req);
    check(z_bin, exp, req);
    check(z_oh, exp, "R9");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    x   = 1'b1;
    @(posedge clk);
    #2;
    check_both(1'b0, "R1");
    @(negedge clk);
    rst = 1'b0;
  endtask

  // drive one bit at the falling edge, sample z before the rising edge
  task automatic step(input logic b, input logic exp, input string req);
    @(negedge clk);
    x = b;
    #2;
    check_both(exp, req);
  endtask

  function automatic logic sbit(input logic [31:0] s, input int len, input int i);
    return s[len-1-i];
  endfunction

  // scan the stream: a 00 pair claims the following three bits
  function automatic logic [31:0] ref_z(input logic [31:0] s, input int len);
    logic [31:0] e;
    int i;
    e = '0;
    i = 0;
    while (i < len) begin
      if (i + 1 < len && !sbit(s, len, i) && !sbit(s, len, i + 1)) begin
        if (i + 4 < len &&
            (sbit(s, len, i + 2) | sbit(s, len, i + 3) | sbit(s, len, i + 4)))
          e[len-1-(i+4)] = 1'b1;
        i = i + 5;
      end else begin
        i = i + 1;
      end
    end
    return e;
  endfunction

  task automatic run_seq(input logic [31:0] s, input int len, input string req);
    logic [31:0] e;
    e = ref_z(s, len);
    do_reset();
    for (int i = 0; i < len; i++) step(s[len-1-i], e[len-1-i], req);
  endtask

  initial begin
    logic [24:0] ex_x, ex_z;
    ex_x = 25'b0100010010010010000000011;
    ex_z = 25'b0000001000000100000000001;

    // R8 worked example against the literal output stream
    do_reset();
    for (int i = 24; i >= 0; i--) step(ex_x[i], ex_z[i], "R8");

    // R2 trigger then a 1 in the first window slot
    run_seq(32'b00100, 5, "R2");
    // R3 a 1 breaks a pending zero
    run_seq(32'b010111, 6, "R3");
    run_seq(32'b0101010111, 10, "R3");
    // R4 a 1 just after the window is ignored
    run_seq(32'b000001, 6, "R4");
    // R6 window zeros do not form the next trigger
    run_seq(32'b0000000001, 10, "R6");
    run_seq(32'b0000001000, 10, "R6");

    // R1 reset during a window discards it
    do_reset();
    step(1'b0, 1'b0, "R1");
    step(1'b0, 1'b0, "R1");
    step(1'b1, 1'b0, "R1");
    do_reset();
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b0, "R1");

    // R7 Mealy response inside the third slot
    do_reset();
    step(1'b0, 1'b0, "R7");
    step(1'b0, 1'b0, "R7");
    step(1'b0, 1'b0, "R7");
    step(1'b0, 1'b0, "R7");
    step(1'b0, 1'b0, "R7");
    x = 1'b1;
    #2;
    check_both(1'b1, "R7");
    x = 1'b0;
    #2;
    check_both(1'b0, "R7");

    // R5 exhaustive sweep of ten-bit streams
    for (int p = 0; p < 1024; p++) run_seq(32'(p), 10, "R5");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule